// File: doc/BRIEF.md
# Timed Fade Dimmer

This block holds the 8-bit light level of a lamp driver and moves it toward a commanded target over a programmable fade time. A command decoder upstream presents three single-cycle strobes. The first is a direct level request carrying an 8-bit target. The second loads a 4-bit fade-time code taken from a data-transfer register. The third is a reset command that returns the block to its power-up state.

The fade time for code n (1 to 15) is about 0.5·√(2^n) seconds, counted in 200 µs ticks. Code 0 applies the level at once. Each fade moves the level one count at a time. The steps are spread evenly, so the whole change, of any size, lasts the coded time. A status byte reports two flags that a status query can read: whether a fade is running and whether the lamp is on.

Top module: `fade_dimmer`

## Requirements
- R1: After rst_n is low, or on the clock edge that accepts a reset_cmd strobe, the fade code is 0, the level is 254 and status reads 8'h04. reset_cmd takes priority over any other strobe in the same cycle.
- R2: fade_load stores fade_code. While the stored code is 0, an arc_req sets level to arc_value on the accepting edge and status bit 4 stays 0.
- R3: With a code n of 1 or more, a fade lasts T(n) ticks. T(n) is 2500·2^(n/2) for even n and 3536·2^((n-1)/2) for odd n, so code 6 gives 20000 ticks (4 s). After k ticks the level has moved floor(k·D/T(n)) counts from its start toward the target, where D is the distance. The target is reached exactly T(n)·TICK_CYCLES clock cycles after the accepting edge.
- R4: Outside an immediate change or a reset, the level changes by at most one count per clock and never passes its target.
- R5: Status bit 4 (fade running) is 1 from the edge that accepts a fade until the edge on which the level reaches its target, and 0 at all other times.
- R6: Status bit 2 (lamp on) is 1 exactly when the level is non-zero. Status bits 7, 6, 5, 3, 1 and 0 are always 0.
- R7: A fade request with a non-zero code leaves the level unchanged on the accepting edge. A fade to 0 does not switch the lamp off at once.
- R8: An arc_req during a fade restarts the fade from the present level toward the new target, with a full T(n) duration.
- R9: An arc_req whose target equals the present level starts no fade, and status bit 4 stays 0.
- R10: When fade_load and arc_req are strobed in the same cycle, the request uses the newly loaded code.
- R11: A tick is TICK_CYCLES = CLK_HZ/TICK_HZ clock cycles long, counted from the accepting edge. The first step of a fade covering D counts lands ceil(T(n)/D)·TICK_CYCLES cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arc_req | input | 1 | Direct level request strobe |
| arc_value | input | 8 | Target level for arc_req |
| fade_load | input | 1 | Store fade_code as the fade time |
| fade_code | input | 4 | Fade-time code from the data-transfer register |
| reset_cmd | input | 1 | Reset command strobe |
| level | output | 8 | Present light level |
| status | output | 8 | Status byte: bit 4 fade running, bit 2 lamp on |

## Verification
The bench sets CLK_HZ to 10000 and keeps TICK_HZ at 5000, so a tick lasts two clock cycles instead of ten thousand. With ticks this short, a full 4-second fade to off, an odd-code fade, a restart in the middle of a fade and the timing of the first step all fit in a short run. The exact cycle on which the final step lands can then be compared against the model, and so can the cycle just before it.

// File: rtl/fade_dimmer.sv
module fade_dimmer #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arc_req,
  input  logic [7:0] arc_value,
  input  logic       fade_load,
  input  logic [3:0] fade_code,
  input  logic       reset_cmd,
  output logic [7:0] level,
  output logic [7:0] status
);
  localparam int TC = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int TW = (TC > 1) ? $clog2(TC) : 1;
  localparam int AW = 20;
  localparam logic [7:0] LVL_RESET = 8'd254;

  function automatic logic [AW-1:0] fade_ticks(input logic [3:0] c);
    logic [AW-1:0] base;
    logic [3:0] sh;
    base = c[0] ? AW'(3536) : AW'(2500);
    sh = c[0] ? ((c - 4'd1) >> 1) : (c >> 1);
    return base << sh;
  endfunction

  logic [TW-1:0] cnt;
  logic [3:0]    code_q;
  logic [7:0]    level_q, target_q, delta_q;
  logic [AW-1:0] total_q, acc_q;
  logic          running;

  wire [3:0]  eff_code   = fade_load ? fade_code : code_q;
  wire        tick       = running && (cnt == TW'(TC - 1));
  wire [AW:0] acc_sum    = {1'b0, acc_q} + (AW+1)'(delta_q);
  wire        step       = tick && (acc_sum >= {1'b0, total_q});
  wire [7:0]  level_step = (target_q > level_q) ? level_q + 8'd1 : level_q - 8'd1;
  wire        idle_move  = arc_req && (eff_code == 4'd0 || arc_value == level_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; code_q <= '0; level_q <= LVL_RESET; target_q <= LVL_RESET;
      delta_q <= '0; total_q <= '0; acc_q <= '0; running <= 1'b0;
    end else if (reset_cmd) begin
      cnt <= '0; code_q <= '0; level_q <= LVL_RESET; target_q <= LVL_RESET;
      delta_q <= '0; total_q <= '0; acc_q <= '0; running <= 1'b0;
    end else begin
      if (fade_load) code_q <= fade_code;
      if (arc_req) begin
        target_q <= arc_value;
        acc_q    <= '0;
        cnt      <= '0;
        delta_q  <= (arc_value > level_q) ? arc_value - level_q : level_q - arc_value;
        total_q  <= fade_ticks(eff_code);
        if (idle_move) begin
          level_q <= arc_value;
          running <= 1'b0;
        end else begin
          running <= 1'b1;
        end
      end else if (running) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) acc_q <= step ? AW'(acc_sum - {1'b0, total_q}) : acc_sum[AW-1:0];
        if (step) begin
          level_q <= level_step;
          if (level_step == target_q) running <= 1'b0;
        end
      end
    end
  end

  assign level  = level_q;
  assign status = {3'b000, running, 1'b0, level_q != 8'd0, 2'b00};

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (level == LVL_RESET && status == 8'h04));
  // R2
  immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arc_req && !reset_cmd && eff_code == 4'd0) |=> (level == $past(arc_value) && !status[4]));
  // R7
  no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arc_req && !reset_cmd && !idle_move) |=> (level == $past(level) && status[4]));
  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_cmd && !idle_move) |=>
      (level == $past(level) || level == $past(level) + 8'd1 || level == $past(level) - 8'd1));
  // R5
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[4] && !arc_req && !reset_cmd) |=> $stable(level));
endmodule

// File: tb/test_fade_dimmer.sv
module test_fade_dimmer;
  localparam int N = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic arc_req = 0, fade_load = 0, reset_cmd = 0;
  logic [7:0] arc_value = 0;
  logic [3:0] fade_code = 0;
  logic [7:0] level, status;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  fade_dimmer #(.CLK_HZ(10000), .TICK_HZ(5000)) i_fade_dimmer (
    .clk(clk), .rst_n(rst_n), .arc_req(arc_req), .arc_value(arc_value),
    .fade_load(fade_load), .fade_code(fade_code), .reset_cmd(reset_cmd),
    .level(level), .status(status));

  function automatic int ticks_of(input int n);
    return (n % 2 == 1) ? 3536 * (1 << ((n - 1) / 2)) : 2500 * (1 << (n / 2));
  endfunction

  int m_level, m_start, m_target, m_delta, m_total, m_code, m_e;
  bit m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || reset_cmd) begin
      m_level = 254; m_code = 0; m_run = 0; m_e = 0;
    end else begin
      if (fade_load) m_code = fade_code;
      if (arc_req) begin
        if (m_code == 0 || int'(arc_value) == m_level) begin
          m_level = arc_value; m_run = 0;
        end else begin
          m_start = m_level; m_target = arc_value; m_e = 0; m_run = 1;
          m_total = ticks_of(m_code);
          m_delta = (m_target > m_start) ? m_target - m_start : m_start - m_target;
        end
      end else if (m_run) begin
        int k, moved;
        m_e++;
        k = m_e / N;
        moved = (k * m_delta) / m_total;
        m_level = (m_target > m_start) ? m_start + moved : m_start - moved;
        if (k >= m_total) m_run = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  bit compare_on = 0;
  always @(negedge clk) if (compare_on && rst_n) begin
    int exp_st;
    exp_st = (m_run ? 16 : 0) + (m_level != 0 ? 4 : 0);
    chk(int'(level) == m_level, "R3 R4 model level", level, m_level);
    chk(int'(status) == exp_st, "R5 R6 model status", status, exp_st);
  end

  task automatic pulse(input bit a, input int v, input bit fl, input int fc, input bit rc);
    arc_req = a; arc_value = 8'(v); fade_load = fl; fade_code = 4'(fc); reset_cmd = rc;
    @(negedge clk);
    arc_req = 0; fade_load = 0; reset_cmd = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_on = 1;
    chk(level == 8'd254, "R1 reset level", level, 254);
    chk(status == 8'h04, "R1 reset status", status, 4);
    pulse(1, 100, 0, 0, 0);
    chk(level == 8'd100, "R2 immediate level", level, 100);
    chk(status[4] == 1'b0, "R2 no fade flag", status[4], 0);
    pulse(0, 0, 1, 6, 0);
    pulse(1, 0, 0, 0, 0);
    chk(level == 8'd100, "R7 no drop at accept", level, 100);
    chk(status == 8'h14, "R5 fading status", status, 20);
    wait_cyc(3000);
    chk(status[2] == 1'b1, "R6 lamp on at 300ms", status[2], 1);
    chk(status[4] == 1'b1, "R5 running at 300ms", status[4], 1);
    chk(level == 8'd93, "R3 level at 300ms", level, 93);
    wait_cyc(36999);
    chk(level == 8'd1, "R3 one step before end", level, 1);
    wait_cyc(1);
    chk(level == 8'd0, "R3 4s fade end", level, 0);
    chk(status == 8'h00, "R5 R6 status after fade", status, 0);
    wait_cyc(10000);
    chk(status[4] == 1'b0, "R5 flag clear at 5s", status[4], 0);
    pulse(0, 0, 1, 1, 0);
    pulse(1, 254, 0, 0, 0);
    wait_cyc(2000);
    chk(level == 8'd71, "R3 code1 midway", level, 71);
    pulse(1, 50, 0, 0, 0);
    chk(level == 8'd71, "R8 restart from present level", level, 71);
    chk(status[4] == 1'b1, "R8 still running", status[4], 1);
    wait_cyc(7071);
    chk(level == 8'd51, "R8 before restarted end", level, 51);
    wait_cyc(1);
    chk(level == 8'd50, "R8 full duration restart", level, 50);
    pulse(0, 0, 1, 3, 0);
    pulse(1, 60, 0, 0, 0);
    wait_cyc(14143);
    chk(level == 8'd59, "R3 odd code before end", level, 59);
    wait_cyc(1);
    chk(level == 8'd60, "R3 odd code end", level, 60);
    pulse(1, 60, 0, 0, 0);
    chk(status == 8'h04, "R9 equal target no fade", status, 4);
    pulse(0, 0, 1, 2, 0);
    pulse(1, 70, 0, 0, 0);
    wait_cyc(999);
    chk(level == 8'd60, "R11 before first step", level, 60);
    wait_cyc(1);
    chk(level == 8'd61, "R11 first step", level, 61);
    wait_cyc(9000);
    chk(level == 8'd70, "R3 code2 end", level, 70);
    pulse(1, 20, 1, 0, 0);
    chk(level == 8'd20, "R10 same-cycle code used", level, 20);
    pulse(0, 0, 1, 5, 0);
    pulse(1, 200, 1, 5, 1);
    chk(level == 8'd254, "R1 reset_cmd priority level", level, 254);
    chk(status == 8'h04, "R1 reset_cmd priority status", status, 4);
    pulse(1, 30, 0, 0, 0);
    chk(level == 8'd30, "R1 code cleared by reset_cmd", level, 30);
    wait_cyc(4);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule